// File: doc/BRIEF.md
# Serial Baud Clock Generator

This block makes the bit timing strobes for a serial port that works either as an asynchronous line or as a clock-synchronous shift link. A two-bit source code picks one of three prescaled versions of the system clock: the full rate, one eighth of it, or a rate divided by twice a four-bit factor. The chosen rate drives a down-counter that fires once every m+1 source pulses, where m is an eight-bit reload value. After that counter, a final stage depends on the mode. In asynchronous mode the counter output is the 16x oversampling strobe, and every sixteenth one is a bit strobe. In synchronous master mode each counter pulse toggles a shift clock. In synchronous mode the port can also be slaved to a clock on an external pin.

Every output is a one-cycle enable in the system clock domain, except the shift clock level, which is meant for the pin. No output has flow control. The strobes are free-running timing marks, so they carry no valid/ready handshake and have no back-pressure. A consumer that misses a strobe loses that bit slot.

Top module: `baud_clk_gen`

## Requirements
- R1: While rst_n is low, os_tick, bit_tick and shift_fall are 0 and sclk_out is 1.
- R2: src_sel encodes the source rate. 2'b00 gives one source pulse every system cycle and 2'b01 gives one every 8 cycles. 2'b10 uses the programmable prescaler of R3.
- R3: For src_sel 2'b10, presc_n = 0 gives a pulse every cycle. A value n from 1 to 15 gives a pulse every 2n cycles.
- R4: src_sel 2'b11 is reserved and stops the chain. Once it has been applied for two cycles, os_tick, bit_tick and shift_fall stay 0.
- R5: The reload counter fires once every reload_m+1 source pulses. A new reload_m is loaded only when the count reaches zero, so the interval already under way keeps its old length.
- R6: With sync_mode = 0, os_tick pulses once per counter period and bit_tick pulses once per 16 os_ticks. shift_fall stays 0 and sclk_out stays 1.
- R7: With sync_mode = 1 and ext_clk_sel = 0, sclk_out toggles once per counter period. shift_fall pulses on its 1-to-0 transitions and bit_tick on its 0-to-1 transitions. os_tick stays 0.
- R8: With sync_mode = 1 and ext_clk_sel = 1, ext_sclk_in passes through a two-flop synchroniser. Each rising edge gives one bit_tick and each falling edge gives one shift_fall. sclk_out stays 1. In asynchronous mode the pin is ignored.
- R9: bit_tick and shift_fall are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel | input | 2 | Source rate code |
| presc_n | input | 4 | Programmable prescaler factor |
| reload_m | input | 8 | Reload value of the m+1 counter |
| sync_mode | input | 1 | 1 = clock-synchronous, 0 = asynchronous |
| ext_clk_sel | input | 1 | 1 = shift clock from the external pin (synchronous mode only) |
| ext_sclk_in | input | 1 | External shift clock pin |
| os_tick | output | 1 | 16x oversampling strobe (asynchronous mode) |
| bit_tick | output | 1 | Bit strobe; sample edge in synchronous mode |
| shift_fall | output | 1 | Shift-out strobe on the falling shift clock edge |
| sclk_out | output | 1 | Master shift clock level, idle high |

## Verification
The assertions assume that the configuration inputs change only between bursts of activity and not on every cycle. They also assume that the external pin, once synchronised, stays at each level for at least one system cycle. The bench changes the settings only at falling clock edges and then waits out two full output periods before it measures anything. It drives the external clock with pulses several cycles wide. The reload test is the one exception. There reload_m is changed on purpose in the middle of a count, to show that the new value waits for the next reload.

// File: rtl/bgen_pkg.sv
package bgen_pkg;
  typedef enum logic [1:0] {
    SRC_FULL  = 2'b00,
    SRC_DIV8  = 2'b01,
    SRC_PRESC = 2'b10,
    SRC_OFF   = 2'b11
  } src_e;

  localparam int FIX_DIV_DEF = 8;
  localparam int OS_RATIO_DEF = 16;
endpackage

// File: rtl/bgen_prescaler.sv
module bgen_prescaler
  import bgen_pkg::*;
#(
  parameter int NW      = 4,
  parameter int FIX_DIV = FIX_DIV_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  src_e          src,
  input  logic [NW-1:0] n_fac,
  output logic          src_en
);
  localparam int FW = $clog2(FIX_DIV);
  localparam int CW = NW + 1;

  logic [FW-1:0] fix_cnt;
  logic [CW-1:0] prog_cnt;
  logic [CW-1:0] prog_lim;
  logic          fix_pulse;
  logic          prog_hit;
  logic          prog_pulse;

  // fixed divide: free-running wrap counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fix_cnt <= '0;
    else        fix_cnt <= fix_cnt + 1'b1;
  end
  assign fix_pulse = (fix_cnt == FW'(FIX_DIV - 1));

  // programmable divide by 2n; n = 0 means no division
  assign prog_lim   = {n_fac, 1'b0} - CW'(1);
  assign prog_hit   = (prog_cnt >= prog_lim);
  assign prog_pulse = (n_fac == '0) || prog_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prog_cnt <= '0;
    else if (prog_hit) prog_cnt <= '0;
    else               prog_cnt <= prog_cnt + 1'b1;
  end

  always_comb begin
    unique case (src)
      SRC_FULL:  src_en = 1'b1;
      SRC_DIV8:  src_en = fix_pulse;
      SRC_PRESC: src_en = prog_pulse;
      default:   src_en = 1'b0;
    endcase
  end

  // R2: a fixed-divide pulse is never followed by another one in the next cycle
  a_r2_div8_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    fix_pulse |=> !fix_pulse);

  // R3: the programmable count never runs past its limit by more than one reload
  a_r3_prog_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (n_fac != '0 && $stable(n_fac) && prog_cnt <= prog_lim) |=> prog_cnt <= prog_lim);
endmodule

// File: rtl/bgen_reload_div.sv
module bgen_reload_div #(
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [MW-1:0] reload,
  output logic          tick
);
  logic [MW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (en) begin
      if (cnt == '0) begin
        cnt  <= reload;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt - 1'b1;
        tick <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end

  // R5: each tick coincides with a fresh load of the reload value
  a_r5_reload_load: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> cnt == $past(reload));

  // R5: without a source pulse the count holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> ($stable(cnt) && !tick));
endmodule

// File: rtl/bgen_post_div.sv
module bgen_post_div
  import bgen_pkg::*;
#(
  parameter int OS = OS_RATIO_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_tick,
  input  logic async_on,
  input  logic sync_int_on,
  output logic bit_q,
  output logic sclk_q,
  output logic rise_q,
  output logic fall_q
);
  localparam int OW = $clog2(OS);

  logic [OW-1:0] os_cnt;

  // asynchronous: every OS-th oversampling tick is a bit strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_cnt <= '0;
      bit_q  <= 1'b0;
    end else if (!async_on) begin
      os_cnt <= '0;
      bit_q  <= 1'b0;
    end else if (div_tick) begin
      os_cnt <= (os_cnt == OW'(OS - 1)) ? '0 : os_cnt + 1'b1;
      bit_q  <= (os_cnt == OW'(OS - 1));
    end else begin
      bit_q  <= 1'b0;
    end
  end

  // synchronous master: divide by two into a shift clock, idle high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (!sync_int_on) begin
      sclk_q <= 1'b1;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (div_tick) begin
      sclk_q <= ~sclk_q;
      rise_q <= ~sclk_q;
      fall_q <= sclk_q;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end
  end

  // R6: a bit strobe always marks the wrap of the oversampling count
  a_r6_bit_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q |-> os_cnt == '0);

  // R7: strobes agree with the new shift clock level
  a_r7_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> sclk_q);
  a_r7_fall_level: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |-> !sclk_q);
endmodule

// File: rtl/bgen_ext_edge.sv
module bgen_ext_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic s1, s2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      prev <= 1'b0;
    end else begin
      s1   <= pin;
      s2   <= s1;
      prev <= s2;
    end
  end

  assign rise = s2 & ~prev;
  assign fall = ~s2 & prev;

  // R8: one synchronised edge gives exactly one strobe
  a_r8_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  a_r8_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/baud_clk_gen.sv
module baud_clk_gen
  import bgen_pkg::*;
#(
  parameter int NW      = 4,
  parameter int MW      = 8,
  parameter int FIX_DIV = FIX_DIV_DEF,
  parameter int OS      = OS_RATIO_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    src_sel,
  input  logic [NW-1:0] presc_n,
  input  logic [MW-1:0] reload_m,
  input  logic          sync_mode,
  input  logic          ext_clk_sel,
  input  logic          ext_sclk_in,
  output logic          os_tick,
  output logic          bit_tick,
  output logic          shift_fall,
  output logic          sclk_out
);
  src_e src;
  logic src_en, div_tick;
  logic async_bit, int_sclk, int_rise, int_fall;
  logic ext_rise, ext_fall;
  logic sync_int_on, sync_ext_on;

  assign src         = src_e'(src_sel);
  assign sync_int_on = sync_mode & ~ext_clk_sel;
  assign sync_ext_on = sync_mode & ext_clk_sel;

  bgen_prescaler #(.NW(NW), .FIX_DIV(FIX_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .src(src), .n_fac(presc_n), .src_en(src_en));

  bgen_reload_div #(.MW(MW)) u_div (
    .clk(clk), .rst_n(rst_n), .en(src_en), .reload(reload_m), .tick(div_tick));

  bgen_post_div #(.OS(OS)) u_post (
    .clk(clk), .rst_n(rst_n), .div_tick(div_tick), .async_on(~sync_mode),
    .sync_int_on(sync_int_on), .bit_q(async_bit), .sclk_q(int_sclk),
    .rise_q(int_rise), .fall_q(int_fall));

  bgen_ext_edge u_ext (
    .clk(clk), .rst_n(rst_n), .pin(ext_sclk_in), .rise(ext_rise), .fall(ext_fall));

  always_comb begin
    os_tick    = 1'b0;
    bit_tick   = 1'b0;
    shift_fall = 1'b0;
    sclk_out   = 1'b1;
    if (!sync_mode) begin
      os_tick  = div_tick;
      bit_tick = async_bit;
    end else if (sync_ext_on) begin
      bit_tick   = ext_rise;
      shift_fall = ext_fall;
    end else begin
      bit_tick   = int_rise;
      shift_fall = int_fall;
      sclk_out   = int_sclk;
    end
  end

  // R4: a reserved source code silences the counter
  a_r4_reserved_stops: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_sel) == 2'b11) |-> !div_tick);

  // R9: sample and shift strobes never collide
  a_r9_no_collide: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bit_tick, shift_fall}));

  // R6: the asynchronous path never drives the shift clock
  a_r6_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |-> (sclk_out && !shift_fall));
endmodule

// File: tb/test_baud_clk_gen.sv
module test_baud_clk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic [3:0] presc_n = '0;
  logic [7:0] reload_m = '0;
  logic       sync_mode = 1'b0;
  logic       ext_clk_sel = 1'b0;
  logic       ext_sclk_in = 1'b0;
  logic       os_tick, bit_tick, shift_fall, sclk_out;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  baud_clk_gen i_baud_clk_gen (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .presc_n(presc_n),
    .reload_m(reload_m), .sync_mode(sync_mode), .ext_clk_sel(ext_clk_sel),
    .ext_sclk_in(ext_sclk_in), .os_tick(os_tick), .bit_tick(bit_tick),
    .shift_fall(shift_fall), .sclk_out(sclk_out));

  typedef struct packed {
    logic [1:0]  src;
    logic [3:0]  n;
    logic [7:0]  m;
    logic        sync;
    logic [15:0] per;
  } vec_t;

  // expected bit period = prescale * (m+1) * (16 async | 2 sync)
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 4'd0,  8'd3, 1'b0, 16'd64},
    '{2'b01, 4'd0,  8'd2, 1'b0, 16'd384},
    '{2'b10, 4'd0,  8'd4, 1'b0, 16'd80},
    '{2'b10, 4'd1,  8'd1, 1'b0, 16'd64},
    '{2'b10, 4'd3,  8'd0, 1'b0, 16'd96},
    '{2'b10, 4'd15, 8'd1, 1'b0, 16'd960},
    '{2'b00, 4'd0,  8'd0, 1'b1, 16'd2},
    '{2'b00, 4'd0,  8'd5, 1'b1, 16'd12},
    '{2'b01, 4'd0,  8'd1, 1'b1, 16'd32},
    '{2'b10, 4'd2,  8'd2, 1'b1, 16'd24}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int which);
    case (which)
      0:       return os_tick;
      1:       return bit_tick;
      default: return shift_fall;
    endcase
  endfunction

  // returns the cycle stamp of the next strobe, or -1 on timeout
  task automatic wait_sig(input int which, input int limit, output int t);
    int start;
    start = cyc;
    t = -1;
    forever begin
      @(negedge clk);
      if (pick(which)) begin t = cyc; break; end
      if (cyc - start > limit) break;
    end
  endtask

  task automatic period(input int which, input int limit, output int p);
    int t0, t1;
    wait_sig(which, limit, t0);
    wait_sig(which, limit, t1);
    p = (t0 < 0 || t1 < 0) ? -1 : t1 - t0;
  endtask

  initial begin
    #(4 * 180000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int p, cnt_a, cnt_b, t0, t1;
    bit hi_ok;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!os_tick && !bit_tick && !shift_fall && sclk_out, "R1 reset outputs",
          {os_tick, bit_tick, shift_fall, sclk_out}, 4'b0001);
    rst_n = 1'b1;

    // table walk: R2 R3 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      src_sel = VEC[i].src; presc_n = VEC[i].n;
      reload_m = VEC[i].m;  sync_mode = VEC[i].sync;
      repeat (2) wait_sig(1, 4000, t0);
      period(1, 4000, p);
      check(p == int'(VEC[i].per), "R2 R3 R5 bit_tick period", p, VEC[i].per);
      if (!VEC[i].sync) begin
        period(0, 4000, p);
        check(p == int'(VEC[i].per) / 16, "R6 os_tick period", p, VEC[i].per / 16);
      end else begin
        period(2, 4000, p);
        check(p == int'(VEC[i].per), "R7 shift_fall period", p, VEC[i].per);
      end
    end

    // R7: sclk_out level and strobe alignment; R9: no collision
    @(negedge clk);
    src_sel = 2'b00; reload_m = 8'd3; sync_mode = 1'b1; ext_clk_sel = 1'b0;
    wait_sig(2, 200, t0);
    check(sclk_out == 1'b0, "R7 sclk low at shift_fall", sclk_out, 0);
    wait_sig(1, 200, t1);
    check(sclk_out == 1'b1 && t1 - t0 == 4, "R7 sclk high at bit_tick", t1 - t0, 4);
    cnt_a = 0;
    repeat (200) begin
      @(negedge clk);
      if (bit_tick && shift_fall) cnt_a++;
    end
    check(cnt_a == 0, "R9 no same-cycle strobes", cnt_a, 0);

    // R5: reload change mid-count waits for reload
    @(negedge clk);
    sync_mode = 1'b0; reload_m = 8'd3;
    repeat (3) wait_sig(0, 200, t0);
    reload_m = 8'd9;
    wait_sig(0, 200, t1);
    check(t1 - t0 == 4, "R5 old interval kept", t1 - t0, 4);
    wait_sig(0, 200, t0);
    check(t0 - t1 == 10, "R5 new interval after reload", t0 - t1, 10);

    // R4: reserved source code stops everything
    @(negedge clk);
    src_sel = 2'b11; reload_m = 8'd0;
    repeat (3) @(negedge clk);
    cnt_a = 0;
    repeat (400) begin
      @(negedge clk);
      if (os_tick || bit_tick || shift_fall) cnt_a++;
    end
    check(cnt_a == 0, "R4 reserved code silent", cnt_a, 0);

    // R8: external clock slave
    @(negedge clk);
    src_sel = 2'b00; reload_m = 8'd0; sync_mode = 1'b1; ext_clk_sel = 1'b1;
    ext_sclk_in = 1'b0;
    repeat (6) @(negedge clk);
    cnt_a = 0; cnt_b = 0; hi_ok = 1'b1;
    for (int k = 0; k < 6; k++) begin
      ext_sclk_in = 1'b1;
      repeat (4) begin
        @(negedge clk);
        cnt_a += bit_tick; cnt_b += shift_fall; hi_ok &= sclk_out;
      end
      ext_sclk_in = 1'b0;
      repeat (4) begin
        @(negedge clk);
        cnt_a += bit_tick; cnt_b += shift_fall; hi_ok &= sclk_out;
      end
    end
    repeat (6) begin
      @(negedge clk);
      cnt_a += bit_tick; cnt_b += shift_fall; hi_ok &= sclk_out;
    end
    check(cnt_a == 6, "R8 one bit_tick per rising edge", cnt_a, 6);
    check(cnt_b == 6, "R8 one shift_fall per falling edge", cnt_b, 6);
    check(hi_ok, "R8 sclk_out held high", hi_ok, 1);

    // R8: pin ignored in asynchronous mode
    @(negedge clk);
    sync_mode = 1'b0; reload_m = 8'd1;
    cnt_b = 0;
    repeat (20) begin
      ext_sclk_in = ~ext_sclk_in;
      repeat (3) begin
        @(negedge clk);
        cnt_b += shift_fall;
      end
    end
    check(cnt_b == 0, "R8 pin ignored when asynchronous", cnt_b, 0);
    period(0, 200, p);
    check(p == 2, "R8 R6 os_tick unaffected by pin", p, 2);

    // R1: reset again mid-activity
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!os_tick && !bit_tick && !shift_fall && sclk_out, "R1 reset re-entry",
          {os_tick, bit_tick, shift_fall, sclk_out}, 4'b0001);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule